// File: doc/BRIEF.md
# Command Issue and Response Capture Unit

This unit sits between a register bus and a card-side command engine in a memory-card host. Software first writes a 16-bit command word. The unit splits that word into its fields and raises a request toward the card engine. The request carries the command index and the expected response kind. The request stays up until the engine returns one response beat. That beat carries up to sixteen response bytes and a count of how many bytes are valid. Serial framing and CRC checking happen in the engine, not here.

On the response beat, the unit places the bytes into eight 16-bit response words. It checks the byte count against the response kind and looks for card error flags. It then sets completion, timeout or error bits in a 16-bit status register. Software clears status bits by writing ones to them. A 15-bit enable mask selects which status bits drive the single interrupt line. For a command that moves data, the unit also pulses a clear toward the data FIFO, latches the transfer direction and flags a transfer as active.

Top module: `cmd_resp_unit`

## Requirements
- R1: The command word is decoded as follows: bits 5:0 are the index, bit 7 is the init flag, bits 10:8 are the response kind, bit 11 is the busy flag, bits 13:12 are the command type and bit 15 is the direction. An accepted word that is not an init-zero command raises `card_req` on the next cycle. At the same time, `card_idx` and `card_rtype` show the index and the response kind. `card_wait_busy` is high only when the response kind is 1 and the busy flag is set.
- R2: A command write while `ctl_enable` is low has no effect. The last-command readback (address 0) stays unchanged and no request is raised.
- R3: An accepted command write sets all eight response words (addresses 8 to 15) to zero.
- R4: An accepted word with the init flag set and index 0 sets status bit 0 and raises no request. It leaves the transfer outputs unchanged.
- R5: Response kinds 1, 3 and 6 need 4 valid bytes, and kind 2 needs 16. If the beat's length is below that, the unit sets status bit 7 instead of the completion bit. The response words then stay zero.
- R6: Response bytes are numbered from 0. Byte 0 is in `card_resp_data[127:120]` and byte 15 is in bits 7:0. The response word at address 8+(7-k) receives {byte 2k, byte 2k+1}. In other words, word i holds `card_resp_data[16i+15:16i]`.
- R7: For kind 1, status bit 14 is set when bytes 0 to 3, read as a big-endian value, share a one with 0xFDF90000. For kind 6, bit 14 is set when bytes 2 and 3 share a one with 0xE008. A short response never sets bit 14.
- R8: A complete response sets status bit 0. If the command index was 12, it sets bits 0 and 2 together.
- R9: A write to the status register (address 1) clears each bit written as one. If a status set lands in the same cycle, the set wins.
- R10: The mask register (address 2) keeps only bits 14:0 of the written value. `irq` is high exactly when the status AND the mask is nonzero.
- R11: An accepted command of type 3 does three things: it pulses `fifo_clr` for one cycle, sets `xfer_active`, and latches bit 15 into `xfer_dir`. An accepted command of any other type clears `xfer_active`.
- R12: Only one command can be outstanding. While `card_req` is high, command writes are ignored. A response beat drops `card_req` on the next cycle. A response beat that arrives with no request outstanding has no effect.
- R13: Response kind 0, or any unlisted kind, always completes, whatever the length. It captures no response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ctl_enable | input | 1 | Controller enable from the control register |
| card_req | output | 1 | Command outstanding toward the card engine |
| card_idx | output | 6 | Index of the outstanding command |
| card_rtype | output | 3 | Expected response kind |
| card_wait_busy | output | 1 | Response kind 1 with busy signalling |
| card_resp_valid | input | 1 | Response beat from the card engine |
| card_resp_len | input | 5 | Number of valid response bytes (0 to 16) |
| card_resp_data | input | 128 | Response bytes, byte 0 in the top bits |
| xfer_active | output | 1 | Data transfer command in progress |
| xfer_dir | output | 1 | Latched transfer direction |
| fifo_clr | output | 1 | One-cycle data FIFO clear |
| irq | output | 1 | Combined interrupt |

## Verification
Any corruption of the outstanding flag shows at once. `card_req` either stays high after a response or drops without one. The next command write is then wrongly accepted or wrongly refused, which shows in the last-command readback. A wrong latched response kind or index shows up one cycle after the response beat. Depending on the fault, it appears as a timeout instead of completion, a missing stop bit or a false error bit. If the interrupt mask has any overlapping bit enabled, the same fault also reaches `irq` in that cycle. Word-order faults in response capture stay hidden until the response words are read. They are caught by reading every word after a full-length response.

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit #(
  parameter logic [31:0] R1_ERR_MASK = 32'hFDF9_0000,
  parameter logic [15:0] R6_ERR_MASK = 16'hE008,
  parameter int          NWORDS      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr_en,
  input  logic [3:0]   reg_addr,
  input  logic [15:0]  reg_wdata,
  output logic [15:0]  reg_rdata,
  input  logic         ctl_enable,
  output logic         card_req,
  output logic [5:0]   card_idx,
  output logic [2:0]   card_rtype,
  output logic         card_wait_busy,
  input  logic         card_resp_valid,
  input  logic [4:0]   card_resp_len,
  input  logic [127:0] card_resp_data,
  output logic         xfer_active,
  output logic         xfer_dir,
  output logic         fifo_clr,
  output logic         irq
);

  localparam logic [3:0] A_CMD  = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;
  localparam logic [3:0] A_MASK = 4'd2;
  localparam int         RSP_LSB_ADDR = 16 - NWORDS;

  logic        pend_q;
  logic [15:0] last_q;
  logic [5:0]  idx_q;
  logic [2:0]  rtype_q;
  logic        bflag_q;
  logic [15:0] st_q, st_n;
  logic [14:0] mask_q;
  logic [15:0] rsp_q [NWORDS];
  logic        act_q, dir_q, clr_q;

  wire cmd_wr    = reg_wr_en && (reg_addr == A_CMD);
  wire stat_wr   = reg_wr_en && (reg_addr == A_STAT);
  wire mask_wr   = reg_wr_en && (reg_addr == A_MASK);
  wire cmd_ok    = cmd_wr && ctl_enable && !pend_q;
  wire init_zero = reg_wdata[7] && (reg_wdata[5:0] == 6'd0);
  wire issue     = cmd_ok && !init_zero;
  wire resp_take = card_resp_valid && pend_q;

  logic       has_rsp;
  logic [4:0] need_len;
  always_comb begin
    case (rtype_q)
      3'd1, 3'd3, 3'd6: begin has_rsp = 1'b1; need_len = 5'd4;  end
      3'd2:             begin has_rsp = 1'b1; need_len = 5'd16; end
      default:          begin has_rsp = 1'b0; need_len = 5'd0;  end
    endcase
  end

  wire short_rsp = has_rsp && (card_resp_len < need_len);
  wire err_r1    = (rtype_q == 3'd1) && |(card_resp_data[127:96] & R1_ERR_MASK);
  wire err_r6    = (rtype_q == 3'd6) && |(card_resp_data[111:96] & R6_ERR_MASK);
  wire card_err  = !short_rsp && (err_r1 || err_r6);
  wire capture   = resp_take && has_rsp && !short_rsp;

  logic [15:0] resp_bits;
  always_comb begin
    resp_bits = 16'h0000;
    if (short_rsp) begin
      resp_bits[7] = 1'b1;
    end else begin
      resp_bits[0]  = 1'b1;
      resp_bits[2]  = (idx_q == 6'd12);
      resp_bits[14] = card_err;
    end
  end

  always_comb begin
    st_n = st_q;
    if (stat_wr)            st_n = st_n & ~reg_wdata;
    if (cmd_ok && init_zero) st_n[0] = 1'b1;
    if (resp_take)          st_n = st_n | resp_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      last_q  <= '0;
      idx_q   <= '0;
      rtype_q <= '0;
      bflag_q <= 1'b0;
      st_q    <= '0;
      mask_q  <= '0;
      act_q   <= 1'b0;
      dir_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      clr_q <= 1'b0;
      if (mask_wr) mask_q <= reg_wdata[14:0];
      if (cmd_ok) last_q <= reg_wdata;
      if (resp_take) pend_q <= 1'b0;
      if (issue) begin
        pend_q  <= 1'b1;
        idx_q   <= reg_wdata[5:0];
        rtype_q <= reg_wdata[10:8];
        bflag_q <= reg_wdata[11];
        if (reg_wdata[13:12] == 2'd3) begin
          act_q <= 1'b1;
          dir_q <= reg_wdata[15];
          clr_q <= 1'b1;
        end else begin
          act_q <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_rsp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rsp_q[i] <= '0;
      else if (cmd_ok)  rsp_q[i] <= '0;
      else if (capture) rsp_q[i] <= card_resp_data[16*i +: 16];
    end
  end

  always_comb begin
    reg_rdata = 16'h0000;
    case (reg_addr)
      A_CMD:   reg_rdata = last_q;
      A_STAT:  reg_rdata = st_q;
      A_MASK:  reg_rdata = {1'b0, mask_q};
      default: if (int'(reg_addr) >= RSP_LSB_ADDR) reg_rdata = rsp_q[int'(reg_addr) - RSP_LSB_ADDR];
    endcase
  end

  assign card_req       = pend_q;
  assign card_idx       = idx_q;
  assign card_rtype     = rtype_q;
  assign card_wait_busy = bflag_q && (rtype_q == 3'd1);
  assign xfer_active    = act_q;
  assign xfer_dir       = dir_q;
  assign fifo_clr       = clr_q;
  assign irq            = |(st_q & {1'b0, mask_q});

  // R12
  resp_ends_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_resp_valid && card_req) |=> !card_req);

  // R2
  disabled_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ctl_enable) |=> ($stable(last_q) && !$rose(card_req)));

  // R4
  init_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && init_zero) |=> (!card_req && st_q[0]));

  // R5
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_resp_valid && card_req) |=> !($rose(st_q[7]) && $rose(st_q[0])));

  // R11
  fifo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |-> (xfer_active && !$past(xfer_active && !card_req)) || xfer_active);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !card_resp_valid) |=> ((st_q & $past(reg_wdata)) == 16'h0000));

  // R10
  mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_MASK) |-> !reg_rdata[15]);

endmodule

// File: tb/cmd_resp_unit_bench.sv
module cmd_resp_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic ctl_enable = 1'b0;
  logic card_req, card_wait_busy, xfer_active, xfer_dir, fifo_clr, irq;
  logic [5:0] card_idx;
  logic [2:0] card_rtype;
  logic card_resp_valid = 1'b0;
  logic [4:0] card_resp_len = '0;
  logic [127:0] card_resp_data = '0;

  always #2.5 clk = ~clk;

  cmd_resp_unit u_cmd_resp_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_enable(ctl_enable),
    .card_req(card_req), .card_idx(card_idx), .card_rtype(card_rtype),
    .card_wait_busy(card_wait_busy), .card_resp_valid(card_resp_valid),
    .card_resp_len(card_resp_len), .card_resp_data(card_resp_data),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir), .fifo_clr(fifo_clr), .irq(irq));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit m_busy, m_act, m_dir, m_clr, m_bflag;
  int m_idx, m_rtype;
  logic [15:0] m_status, m_last;
  logic [14:0] m_mask;
  logic [15:0] m_rsp [8];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_act = 0; m_dir = 0; m_clr = 0; m_bflag = 0;
      m_idx = 0; m_rtype = 0; m_status = 0; m_last = 0; m_mask = 0;
      for (int i = 0; i < 8; i++) m_rsp[i] = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_clr = 0;
      if (reg_wr_en && reg_addr == 1) m_status &= ~reg_wdata;
      if (reg_wr_en && reg_addr == 2) m_mask = reg_wdata[14:0];
      if (reg_wr_en && reg_addr == 0 && ctl_enable && !was_busy) begin
        m_last = reg_wdata;
        for (int i = 0; i < 8; i++) m_rsp[i] = 0;
        if (reg_wdata[7] && reg_wdata[5:0] == 0) m_status[0] = 1;
        else begin
          m_busy = 1; m_idx = reg_wdata[5:0]; m_rtype = reg_wdata[10:8]; m_bflag = reg_wdata[11];
          if (reg_wdata[13:12] == 3) begin m_act = 1; m_dir = reg_wdata[15]; m_clr = 1; end
          else m_act = 0;
        end
      end
      if (card_resp_valid && was_busy) begin
        int need;
        bit has;
        has  = (m_rtype == 1 || m_rtype == 2 || m_rtype == 3 || m_rtype == 6);
        need = (m_rtype == 2) ? 16 : 4;
        if (has && card_resp_len < need) m_status[7] = 1;
        else begin
          if (has) for (int i = 0; i < 8; i++) m_rsp[i] = card_resp_data[16*i +: 16];
          if (m_rtype == 1 && (card_resp_data[127:96] & 32'hFDF90000) != 0) m_status[14] = 1;
          if (m_rtype == 6 && (card_resp_data[111:96] & 16'hE008) != 0) m_status[14] = 1;
          m_status[0] = 1;
          if (m_idx == 12) m_status[2] = 1;
        end
        m_busy = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(card_req == m_busy, "R12 card_req", card_req, m_busy);
      chk(card_idx == m_idx[5:0], "R1 card_idx", card_idx, m_idx);
      chk(card_rtype == m_rtype[2:0], "R1 card_rtype", card_rtype, m_rtype);
      chk(card_wait_busy == (m_bflag && m_rtype == 1), "R1 card_wait_busy", card_wait_busy, m_bflag && m_rtype == 1);
      chk(xfer_active == m_act, "R11 xfer_active", xfer_active, m_act);
      chk(xfer_dir == m_dir, "R11 xfer_dir", xfer_dir, m_dir);
      chk(fifo_clr == m_clr, "R11 fifo_clr", fifo_clr, m_clr);
      chk(irq == |(m_status & {1'b0, m_mask}), "R10 irq", irq, |(m_status & {1'b0, m_mask}));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic resp(input logic [4:0] len, input logic [127:0] data);
    @(negedge clk);
    card_resp_valid = 1; card_resp_len = len; card_resp_data = data;
    @(negedge clk);
    card_resp_valid = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic rd_all_rsp(input string tag);
    for (int i = 0; i < 8; i++) rd(4'(8 + i), m_rsp[i], tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(1, 16'h0000, "R9 reset status");
    rd(2, 16'h0000, "R10 reset mask");
    rd_all_rsp("R3 reset rsp");
    // disabled controller
    wr(0, 16'h0111);
    rd(0, 16'h0000, "R2 disabled cmd readback");
    ctl_enable = 1;
    wr(2, 16'hFFFF);
    rd(2, 16'h7FFF, "R10 mask bit15 dropped");
    // init sequence
    wr(0, 16'h0080);
    rd(1, 16'h0001, "R4 init sets bit0");
    chk(card_req == 0, "R4 no request", card_req, 0);
    wr(1, 16'h0001);
    rd(1, 16'h0000, "R9 w1c clear");
    // normal response with card error, blocked second command
    wr(0, 16'h0111);
    wr(0, 16'h0102);
    rd(0, 16'h0111, "R12 blocked while busy");
    resp(5'd4, 128'h8000_0000_1234_0000_0000_0000_0000_0000);
    rd(1, 16'h4001, "R7 kind1 error bit");
    rd(15, 16'h8000, "R6 word order top");
    rd(13, 16'h1234, "R6 word order third");
    wr(1, 16'hFFFF);
    // long response
    wr(0, 16'h0202);
    resp(5'd16, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF);
    rd(15, 16'h0011, "R6 long first pair");
    rd(8, 16'hEEFF, "R6 long last pair");
    rd_all_rsp("R6 long capture");
    rd(1, 16'h0001, "R8 completion");
    wr(1, 16'hFFFF);
    // response cleared by next command
    wr(0, 16'h0209);
    rd_all_rsp("R3 rsp cleared");
    rd(8, 16'h0000, "R3 rsp low word zero");
    resp(5'd15, {128{1'b1}});
    rd(1, 16'h0080, "R5 short response timeout");
    rd(15, 16'h0000, "R5 no capture on short");
    wr(1, 16'hFFFF);
    // stop command
    wr(0, 16'h010C);
    resp(5'd4, 128'h0);
    rd(1, 16'h0005, "R8 stop bits 0 and 2");
    wr(1, 16'hFFFF);
    // published address: error only from low half
    wr(0, 16'h0603);
    resp(5'd4, 128'hFFFF_0000_0000_0000_0000_0000_0000_0000);
    rd(1, 16'h0001, "R7 kind6 upper half ignored");
    wr(1, 16'hFFFF);
    wr(0, 16'h0603);
    resp(5'd4, 128'h0000_8000_0000_0000_0000_0000_0000_0000);
    rd(1, 16'h4001, "R7 kind6 error");
    wr(1, 16'hFFFF);
    // data command then non-data command
    wr(0, 16'hB111);
    chk(xfer_active && xfer_dir, "R11 data cmd latched", {xfer_active, xfer_dir}, 2'b11);
    resp(5'd4, 128'h0);
    wr(0, 16'h0000);
    chk(!xfer_active, "R11 non-data clears active", xfer_active, 0);
    resp(5'd0, {128{1'b1}});
    rd(1, 16'h0001, "R13 no-response completes");
    rd(15, 16'h0000, "R13 no capture");
    wr(1, 16'hFFFF);
    // stray response
    resp(5'd4, {128{1'b1}});
    rd(1, 16'h0000, "R12 stray response ignored");
    rd(15, 16'h0000, "R12 stray no capture");
    // busy variant
    wr(0, 16'h0901);
    chk(card_wait_busy == 1, "R1 busy variant", card_wait_busy, 1);
    // simultaneous clear and set
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 1; reg_wdata = 16'hFFFF;
    card_resp_valid = 1; card_resp_len = 5'd4; card_resp_data = 128'h0;
    @(negedge clk);
    reg_wr_en = 0; card_resp_valid = 0;
    rd(1, 16'h0001, "R9 set wins over clear");
    // irq masking
    wr(2, 16'h0080);
    chk(irq == 0, "R10 masked off", irq, 0);
    wr(2, 16'h0001);
    chk(irq == 1, "R10 masked on", irq, 1);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule